// File: doc/BRIEF.md
# Four-Phase Handshake Protocol Monitor

This block watches a request/acknowledge handshake that carries a data word from one clock domain to another. It samples `req_i`, `ack_i` and `data_i` on its own clock, all three already brought into that domain by synchronizers outside the block. It tracks the handshake through its four phases and flags the first cycle in which the producer or consumer breaks the protocol.

The monitor is a small deterministic state machine. It has four legal phases (idle, request pending, both high, acknowledge draining) and one failure phase that only reset can leave. The data word is latched when the request is first seen in the idle phase. From then on it is compared against the bus in every cycle in which the request is still held.

When a violation is found, a sticky error flag rises, a single-cycle pulse marks the entry into failure, and a two-bit code records which rule was broken first. The monitor can sit beside a crossing in simulation or in silicon as a protocol watchdog.

Top module: `hs_handshake_mon`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `err_o`, `err_pulse_o` and `err_rule_o` are all zero.
- R2: If the request was pending without acknowledge and the request is then sampled low, in the same cycle the acknowledge arrives or earlier, the monitor fails with code 0 in the following cycle.
- R3: If the acknowledge is sampled low while the phase is both-high, the monitor fails with code 1. This holds whether or not the request stays high.
- R4: If the request is sampled high while the acknowledge is still draining (request low, acknowledge high), the monitor fails with code 2.
- R5: The data word is latched in the cycle the request is first seen in idle. A different bus value in any later cycle with the request still held causes a failure with code 3. Bus changes while idle or after the request drops have no effect.
- R6: When a protocol rule and a data change are broken in the same cycle, the protocol code (0, 1 or 2) is reported, not code 3.
- R7: Once failed, `err_o` stays high and `err_rule_o` keeps its value whatever the inputs do, until reset.
- R8: `err_pulse_o` is high for exactly one cycle, the first cycle in which `err_o` is high.
- R9: Compliant traffic raises no error. This covers back-to-back transfers, request and acknowledge first seen in the same cycle, and an acknowledge that appears alone while idle.
- R10: Reset clears a failure and returns the monitor to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Synchronized request level |
| ack_i | input | 1 | Synchronized acknowledge level |
| data_i | input | DATA_W | Synchronized data word |
| err_o | output | 1 | Sticky failure flag |
| err_pulse_o | output | 1 | One-cycle marker of failure entry |
| err_rule_o | output | 2 | Code of the first broken rule (0..3) |

## Verification
Clean traffic is driven first: bus changes in idle and after the request drops, an acknowledge alone in idle, and a request that arrives together with its acknowledge. This shows that only real violations trip the monitor. Each rule is then broken from the exact phase it guards, including the edge cases where two levels move in one cycle. These tell apart a late request drop from a simultaneous one, and an acknowledge dropping alone from both signals dropping together. A combined acknowledge drop with a data change checks the code priority. After a failure, further toggling shows the flag and code are frozen until reset.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_REQ   = 3'd1,
        PH_BOTH  = 3'd2,
        PH_DRAIN = 3'd3,
        PH_FAIL  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        RULE_REQ_EARLY  = 2'd0,
        RULE_ACK_EARLY  = 2'd1,
        RULE_REQ_AGAIN  = 2'd2,
        RULE_DATA_MOVED = 2'd3
    } rule_e;

    typedef struct packed {
        phase_e phase;
        logic   err;
        logic   pulse;
        rule_e  rule;
    } mon_state_t;

endpackage

// File: rtl/hs_data_guard.sv
module hs_data_guard #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              mismatch_o
);

    logic [DATA_W-1:0] held_d, held_q;

    always_comb begin
        held_d = held_q;
        if (capture_i) begin
            held_d = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            held_q <= held_d;
        end
    end

    assign mismatch_o = (data_i != held_q);

endmodule

// File: rtl/hs_rule_eval.sv
module hs_rule_eval
    import hs_mon_pkg::*;
(
    input  phase_e phase_i,
    input  logic   req_i,
    input  logic   ack_i,
    input  logic   mismatch_i,
    output phase_e next_phase_o,
    output logic   viol_o,
    output rule_e  rule_o,
    output logic   capture_o
);

    always_comb begin
        next_phase_o = phase_i;
        viol_o       = 1'b0;
        rule_o       = RULE_REQ_EARLY;
        capture_o    = 1'b0;
        unique case (phase_i)
            PH_IDLE: begin
                if (req_i) begin
                    capture_o    = 1'b1;
                    next_phase_o = ack_i ? PH_BOTH : PH_REQ;
                end
            end
            PH_REQ: begin
                if (!req_i) begin
                    viol_o = 1'b1;
                    rule_o = RULE_REQ_EARLY;
                end else if (mismatch_i) begin
                    viol_o = 1'b1;
                    rule_o = RULE_DATA_MOVED;
                end else if (ack_i) begin
                    next_phase_o = PH_BOTH;
                end
            end
            PH_BOTH: begin
                if (!ack_i) begin
                    viol_o = 1'b1;
                    rule_o = RULE_ACK_EARLY;
                end else if (!req_i) begin
                    next_phase_o = PH_DRAIN;
                end else if (mismatch_i) begin
                    viol_o = 1'b1;
                    rule_o = RULE_DATA_MOVED;
                end
            end
            PH_DRAIN: begin
                if (req_i) begin
                    viol_o = 1'b1;
                    rule_o = RULE_REQ_AGAIN;
                end else if (!ack_i) begin
                    next_phase_o = PH_IDLE;
                end
            end
            default: begin
                next_phase_o = PH_FAIL;
            end
        endcase
        if (viol_o) begin
            next_phase_o = PH_FAIL;
        end
    end

endmodule

// File: rtl/hs_handshake_mon.sv
module hs_handshake_mon
    import hs_mon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              ack_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              err_o,
    output logic              err_pulse_o,
    output logic [1:0]        err_rule_o
);

    mon_state_t st_d, st_q;
    phase_e     next_phase;
    phase_e     phase_q;
    logic       viol;
    rule_e      rule;
    logic       capture;
    logic       mismatch;

    assign phase_q = st_q.phase;

    hs_data_guard #(.DATA_W(DATA_W)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (capture),
        .data_i     (data_i),
        .mismatch_o (mismatch)
    );

    hs_rule_eval u_eval (
        .phase_i      (phase_q),
        .req_i        (req_i),
        .ack_i        (ack_i),
        .mismatch_i   (mismatch),
        .next_phase_o (next_phase),
        .viol_o       (viol),
        .rule_o       (rule),
        .capture_o    (capture)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (st_q.phase != PH_FAIL) begin
            st_d.phase = next_phase;
            if (viol) begin
                st_d.err   = 1'b1;
                st_d.pulse = 1'b1;
                st_d.rule  = rule;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, err: 1'b0, pulse: 1'b0, rule: RULE_REQ_EARLY};
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o       = st_q.err;
    assign err_pulse_o = st_q.pulse;
    assign err_rule_o  = st_q.rule;

endmodule

// File: rtl/hs_mon_chk.sv
module hs_mon_chk
    import hs_mon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              ack_i,
    input logic [DATA_W-1:0] data_i,
    input phase_e            phase_q,
    input logic              err_o,
    input logic              err_pulse_o,
    input logic [1:0]        err_rule_o
);

    a_r2_req_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_REQ && !req_i) |=> (err_o && err_rule_o == 2'd0));

    a_r3_ack_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_BOTH && !ack_i) |=> (err_o && err_rule_o == 2'd1));

    a_r4_req_reraised: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DRAIN && req_i) |=> (err_o && err_rule_o == 2'd2));

    a_r5_data_moved: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_REQ || phase_q == PH_BOTH) && req_i && !$stable(data_i)) |=> err_o);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (err_o && $stable(err_rule_o)));

    a_r8_pulse_with_err: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |-> err_o);

    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |=> !err_pulse_o);

    a_r8_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> err_pulse_o);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && !err_o) |=> !err_o);

endmodule

bind hs_handshake_mon hs_mon_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .ack_i       (ack_i),
    .data_i      (data_i),
    .phase_q     (phase_q),
    .err_o       (err_o),
    .err_pulse_o (err_pulse_o),
    .err_rule_o  (err_rule_o)
);

// File: tb/tb_hs_handshake_mon.sv
module tb_hs_handshake_mon;

    localparam int CLK_P  = 10;
    localparam int DATA_W = 8;
    localparam int WDOG   = 5000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              ack = 1'b0;
    logic [DATA_W-1:0] data = '0;
    logic              err, pulse;
    logic [1:0]        code;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // behavioural reference
    int              m_ph;
    bit              m_err, m_pulse;
    int              m_code;
    logic [DATA_W-1:0] m_hold;

    always #(CLK_P/2) clk = ~clk;

    hs_handshake_mon #(.DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ack_i(ack), .data_i(data),
        .err_o(err), .err_pulse_o(pulse), .err_rule_o(code)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_err = 0; m_pulse = 0; m_code = 0; m_hold = '0;
        end else if (m_err) begin
            m_pulse = 0;
        end else begin
            int v;
            v = -1;
            if (m_ph == 0) begin
                if (req) begin m_hold = data; m_ph = ack ? 2 : 1; end
            end else if (m_ph == 1) begin
                if (!req) v = 0;
                else if (data != m_hold) v = 3;
                else if (ack) m_ph = 2;
            end else if (m_ph == 2) begin
                if (!ack) v = 1;
                else if (!req) m_ph = 3;
                else if (data != m_hold) v = 3;
            end else begin
                if (req) v = 2;
                else if (!ack) m_ph = 0;
            end
            m_pulse = (v >= 0);
            if (v >= 0) begin m_err = 1; m_code = v; end
        end
    end

    task automatic check(string tag, bit e, bit p, int c);
        checks++;
        if (err !== e || pulse !== p || code !== c[1:0]) begin
            errors++;
            $display("FAIL %s: err/pulse/code actual=%0b/%0b/%0d expected=%0b/%0b/%0d",
                     tag, err, pulse, code, e, p, c);
        end
    endtask

    // compare against the model on every cycle
    always @(negedge clk) begin
        if (rst_n && !done) check(cur_tag, m_err, m_pulse, m_code);
    end

    task automatic step(bit r, bit a, logic [DATA_W-1:0] d);
        @(negedge clk);
        req = r; ack = a; data = d;
    endtask

    task automatic expect_now(string tag, bit e, bit p, int c);
        @(posedge clk);
        #1;
        check(tag, e, p, c);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = 1'b0; ack = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: state during and after reset
        #1;
        check("R1", 1'b0, 1'b0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        expect_now("R1", 1'b0, 1'b0, 0);

        // R9 and R5 ignored-change parts: clean traffic
        cur_tag = "R9";
        step(0,0,8'h11); step(0,0,8'h22); step(0,1,8'h22); step(0,0,8'h22);
        step(1,0,8'h33); step(1,0,8'h33); step(1,1,8'h33); step(1,1,8'h33);
        cur_tag = "R5";
        step(0,1,8'h44); step(0,1,8'h55); step(0,0,8'h55);
        cur_tag = "R9";
        step(1,1,8'h66); step(1,1,8'h66); step(0,1,8'h66); step(0,0,8'h67);
        expect_now("R9", 1'b0, 1'b0, 0);

        // R2 late request drop, then R8, R7, R10
        cur_tag = "R2";
        step(1,0,8'h05); step(0,0,8'h05);
        expect_now("R2", 1'b1, 1'b1, 0);
        cur_tag = "R7";
        step(1,1,8'h09);
        expect_now("R8", 1'b1, 1'b0, 0);
        step(0,0,8'h09); step(1,0,8'h01); step(0,1,8'h02);
        expect_now("R7", 1'b1, 1'b0, 0);
        cur_tag = "R10";
        do_reset();
        expect_now("R10", 1'b0, 1'b0, 0);

        // R2 request drops in the cycle the acknowledge arrives
        cur_tag = "R2";
        step(1,0,8'h05); step(0,1,8'h05);
        expect_now("R2", 1'b1, 1'b1, 0);
        do_reset();

        // R3 acknowledge drops alone, then both drop together
        cur_tag = "R3";
        step(1,0,8'h07); step(1,1,8'h07); step(1,0,8'h07);
        expect_now("R3", 1'b1, 1'b1, 1);
        do_reset();
        step(1,1,8'h07); step(0,0,8'h07);
        expect_now("R3", 1'b1, 1'b1, 1);
        do_reset();

        // R4 request raised while acknowledge drains
        cur_tag = "R4";
        step(1,1,8'h03); step(0,1,8'h03); step(1,1,8'h03);
        expect_now("R4", 1'b1, 1'b1, 2);
        do_reset();

        // R5 data moves with request pending, then with both high
        cur_tag = "R5";
        step(1,0,8'h03); step(1,0,8'h04);
        expect_now("R5", 1'b1, 1'b1, 3);
        do_reset();
        step(1,0,8'h03); step(1,1,8'h03); step(1,1,8'h08);
        expect_now("R5", 1'b1, 1'b1, 3);
        do_reset();

        // R6 protocol code wins over data code
        cur_tag = "R6";
        step(1,1,8'h03); step(1,0,8'h09);
        expect_now("R6", 1'b1, 1'b1, 1);
        do_reset();
        step(0,0,8'h00);
        expect_now("R10", 1'b0, 1'b0, 0);

        finish_run();
    end

endmodule